// File: doc/BRIEF.md
# PHY Reset Pulse Sequencer

This block drives the hardware reset pin of an external Ethernet PHY with a timed three-step waveform. After a start request it first parks the pin at its inactive level, then asserts reset, then releases it. Each step is followed by its own wait, programmed in microseconds. A single-cycle completion pulse marks the end. The pin's active level can be chosen as high or low, so the block fits PHYs with either reset sense.

A microsecond prescaler is built from the system clock frequency given as a parameter. The number of clock cycles per microsecond is rounded up, so a programmed wait is never shorter than asked. The delays and the polarity are captured when the sequence starts, so the inputs may change freely while it runs.

Top module: `phy_reset_sequencer`

## Requirements
- R1: While no sequence is running, including from reset, `phy_rst_o` equals `active_low_i`. This is the inactive level: 1 for an active-low pin, 0 for an active-high pin. It follows the live input.
- R2: A start pulse seen in idle at a clock edge begins the first step. For the next `1 + dly_lead_us_i*P` cycles the pin sits at the inactive level of the polarity captured at that edge. P is cycles per microsecond.
- R3: The second step follows at once. For `1 + dly_hold_us_i*P` cycles the pin is at the active level, which is the inverse of the captured `active_low_i`.
- R4: The third step follows at once. For `1 + dly_tail_us_i*P` cycles the pin is back at the captured inactive level.
- R5: A zero delay adds no wait: its step lasts exactly one clock cycle.
- R6: P = ceil(CLK_FREQ_HZ / 1,000,000). With a fractional ratio, the wait is rounded up and is never shorter than the request.
- R7: `done_o` is high for exactly one cycle, in the first cycle after the third step. The sequencer is idle again in that cycle.
- R8: A start pulse received while a sequence is running has no effect on the waveform or on the timing of `done_o`.
- R9: Changes to the delay inputs or to `active_low_i` during a sequence do not alter that sequence's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the reset waveform; used only while idle |
| active_low_i | input | 1 | 1: PHY reset is active low; 0: active high |
| dly_lead_us_i | input | DLY_W | Wait after the first, inactive step, in microseconds |
| dly_hold_us_i | input | DLY_W | Wait with reset asserted, in microseconds |
| dly_tail_us_i | input | DLY_W | Wait after release, in microseconds |
| phy_rst_o | output | 1 | Reset pin to the PHY |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A wrong step state or a miscounted delay moves a pin edge. The pin is compared every cycle against a model, so the error shows in the first cycle it occurs. A prescaler off by one cycle per tick grows with the delay, and is caught at the first step boundary. Two instances with an integer and a fractional clock ratio expose a wrong rounding. Late starts and mid-run input changes show up at once as a shifted edge or a wrong level on the pin.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam longint unsigned US_PER_S = 64'd1_000_000;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_HOLD = 2'd2,
        PH_TAIL = 2'd3
    } seq_ph_e;

    // Cycles per microsecond, rounded up so waits never fall short.
    function automatic int unsigned cyc_per_us(input longint unsigned clk_hz);
        longint unsigned q;
        q = (clk_hz + US_PER_S - 64'd1) / US_PER_S;
        if (q == 0) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/rst_seq_tick.sv
module rst_seq_tick #(
    parameter int unsigned DIV = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_in;
            assign unused_in = ^{clk_i, rst_ni, clr_i};
            assign tick_o    = 1'b1;
        end else begin : g_div
            localparam int unsigned W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q + 1'b1;
                if (clr_i || cnt_q == LAST) cnt_d = '0;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_d;
            end

            assign tick_o = !clr_i && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned DLY_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             active_low_i,
    input  logic [DLY_W-1:0] dly_lead_i,
    input  logic [DLY_W-1:0] dly_hold_i,
    input  logic [DLY_W-1:0] dly_tail_i,
    input  logic             tick_i,
    output logic             clr_o,
    output logic             running_o,
    output logic             pin_o,
    output logic             done_o
);
    typedef struct packed {
        seq_ph_e          ph;
        logic [DLY_W-1:0] cnt;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] tail;
        logic             pol;
        logic             done;
    } fsm_st_t;

    fsm_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        clr_o    = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                clr_o = 1'b1;
                if (start_i) begin
                    s_d.ph   = PH_LEAD;
                    s_d.cnt  = dly_lead_i;
                    s_d.hold = dly_hold_i;
                    s_d.tail = dly_tail_i;
                    s_d.pol  = active_low_i;
                end
            end
            PH_LEAD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = s_q.hold;
                    clr_o   = 1'b1;
                end else if (tick_i) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_TAIL;
                    s_d.cnt = s_q.tail;
                    clr_o   = 1'b1;
                end else if (tick_i) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_TAIL: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                    clr_o    = 1'b1;
                end else if (tick_i) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, hold: '0, tail: '0, pol: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.ph)
            PH_IDLE: pin_o = active_low_i;
            PH_HOLD: pin_o = ~s_q.pol;
            default: pin_o = s_q.pol;
        endcase
    end

    assign running_o = (s_q.ph != PH_IDLE);
    assign done_o    = s_q.done;
endmodule

// File: rtl/phy_reset_sequencer.sv
module phy_reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 250_000_000,
    parameter int unsigned     DLY_W       = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             active_low_i,
    input  logic [DLY_W-1:0] dly_lead_us_i,
    input  logic [DLY_W-1:0] dly_hold_us_i,
    input  logic [DLY_W-1:0] dly_tail_us_i,
    output logic             phy_rst_o,
    output logic             done_o
);
    localparam int unsigned CYC_PER_US = cyc_per_us(CLK_FREQ_HZ);

    logic us_tick;
    logic presc_clr;
    logic seq_running;

    rst_seq_tick #(.DIV(CYC_PER_US)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (presc_clr),
        .tick_o (us_tick)
    );

    rst_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .active_low_i (active_low_i),
        .dly_lead_i   (dly_lead_us_i),
        .dly_hold_i   (dly_hold_us_i),
        .dly_tail_i   (dly_tail_us_i),
        .tick_i       (us_tick),
        .clr_o        (presc_clr),
        .running_o    (seq_running),
        .pin_o        (phy_rst_o),
        .done_o       (done_o)
    );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic active_low_i,
    input logic pin_i,
    input logic done_i,
    input logic running_i,
    input logic clr_i
);
    p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_i |-> pin_i == active_low_i);

    p_start_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_i && start_i |=> running_i);

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    p_done_ends_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !running_i && $past(running_i));

    p_exit_via_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(running_i) |-> done_i);

    p_pin_moves_at_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_i && $past(running_i) && !$stable(pin_i) |-> $past(clr_i));
endmodule

bind phy_reset_sequencer rst_seq_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .active_low_i (active_low_i),
    .pin_i        (phy_rst_o),
    .done_i       (done_o),
    .running_i    (seq_running),
    .clr_i        (presc_clr)
);

// File: tb/tb_phy_reset_sequencer.sv
module tb_phy_reset_sequencer;
    localparam int DW = 8;
    localparam int PA = 10;  // 10 MHz setting -> 10 cycles per us
    localparam int PB = 3;   // 2.5 MHz setting -> ceil(2.5) = 3

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic al = 1'b1;
    logic [DW-1:0] d0 = '0, d1 = '0, d2 = '0;
    logic pin_a, pin_b, done_a, done_b;
    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    phy_reset_sequencer #(.CLK_FREQ_HZ(10_000_000), .DLY_W(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .active_low_i(al),
        .dly_lead_us_i(d0), .dly_hold_us_i(d1), .dly_tail_us_i(d2),
        .phy_rst_o(pin_a), .done_o(done_a));

    phy_reset_sequencer #(.CLK_FREQ_HZ(2_500_000), .DLY_W(DW)) dut_frac (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .active_low_i(al),
        .dly_lead_us_i(d0), .dly_hold_us_i(d1), .dly_tail_us_i(d2),
        .phy_rst_o(pin_b), .done_o(done_b));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic exp_pin(int j, int l0, int l1, int l2, logic pc, logic live);
        if (j <= l0) return pc;
        if (j <= l0 + l1) return ~pc;
        if (j <= l0 + l1 + l2) return pc;
        return live;
    endfunction

    function automatic string phase_tag(int j, int l0, int l1, int l2);
        if (j <= l0) return (l0 == 1) ? "R5" : "R2";
        if (j <= l0 + l1) return (l1 == 1) ? "R5" : "R3";
        if (j <= l0 + l1 + l2) return (l2 == 1) ? "R5" : "R4";
        return "R1";
    endfunction

    task automatic check1(input bit ok, input string tag, input string what, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Runs one sequence from a negedge; inj = late start (R8), chg = mid-run input changes (R9).
    task automatic run_seq(input int n0, input int n1, input int n2, input logic pol, input bit inj, input bit chg);
        int a0 = n0 * PA + 1, a1 = n1 * PA + 1, a2 = n2 * PA + 1;
        int b0 = n0 * PB + 1, b1 = n1 * PB + 1, b2 = n2 * PB + 1;
        int ta = a0 + a1 + a2, tb = b0 + b1 + b2;
        int tot = ((ta > tb) ? ta : tb) + 2;
        bit pa_ok = 1, da_ok = 1, pb_ok = 1, db_ok = 1;
        int pa_j = 0, pb_j = 0, da_j = 0, db_j = 0;
        logic pa_v = 0, pb_v = 0, pa_e = 0, pb_e = 0;
        string ta_tag = "R2", tb_tag = "R6";
        d0 = DW'(n0); d1 = DW'(n1); d2 = DW'(n2); al = pol;
        start_a = 1'b1; start_b = 1'b1;
        for (int j = 1; j <= tot; j++) begin
            logic ea, eb;
            @(negedge clk);
            ea = exp_pin(j, a0, a1, a2, pol, al);
            eb = exp_pin(j, b0, b1, b2, pol, al);
            if (pa_ok && pin_a !== ea) begin
                pa_ok = 0; pa_j = j; pa_v = pin_a; pa_e = ea;
                ta_tag = inj ? "R8" : chg ? "R9" : phase_tag(j, a0, a1, a2);
            end
            if (pb_ok && pin_b !== eb) begin
                pb_ok = 0; pb_j = j; pb_v = pin_b; pb_e = eb;
            end
            if (da_ok && done_a !== (j == ta + 1)) begin da_ok = 0; da_j = j; end
            if (db_ok && done_b !== (j == tb + 1)) begin db_ok = 0; db_j = j; end
            if (j == 1) begin start_a = 1'b0; start_b = 1'b0; end
            if (inj && j == 2) start_a = 1'b1;
            if (inj && j == 3) start_a = 1'b0;
            if (chg && j == 2) begin
                al = ~al;
                d0 = DW'($urandom % 8); d1 = DW'($urandom % 8); d2 = DW'($urandom % 8);
            end
        end
        check1(pa_ok, ta_tag, $sformatf("pin (P=10) at cycle %0d", pa_j), int'(pa_v), int'(pa_e));
        check1(da_ok, inj ? "R8" : "R7", $sformatf("done (P=10) at cycle %0d, due %0d", da_j, ta + 1),
               int'(done_a), int'(da_j == ta + 1));
        check1(pb_ok, tb_tag, $sformatf("pin (P=3 rounded up) at cycle %0d", pb_j), int'(pb_v), int'(pb_e));
        check1(db_ok, "R7", $sformatf("done (P=3) at cycle %0d, due %0d", db_j, tb + 1),
               int'(done_b), int'(db_j == tb + 1));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset state: pin follows live polarity while idle (R1)
        al = 1'b1;
        #1;
        check1(pin_a === 1'b1, "R1", "pin in reset, active-low", int'(pin_a), 1);
        al = 1'b0;
        #1;
        check1(pin_a === 1'b0, "R1", "pin in reset, active-high", int'(pin_a), 0);
        check1(done_a === 1'b0, "R7", "done in reset", int'(done_a), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        al = 1'b1;
        #1;
        check1(pin_a === 1'b1 && pin_b === 1'b1, "R1", "idle pin after reset, active-low",
               int'(pin_a), 1);
        @(negedge clk);

        // Directed corners
        run_seq(0, 0, 0, 1'b1, 0, 0);   // R5 every step one cycle
        run_seq(0, 0, 0, 1'b0, 0, 0);   // R5 active-high
        run_seq(1, 2, 1, 1'b1, 0, 0);   // R6 fractional rounding on dut_frac
        run_seq(2, 3, 1, 1'b0, 1, 0);   // R8 late start ignored
        run_seq(3, 1, 2, 1'b1, 0, 1);   // R9 inputs change mid-run
        run_seq(1, 0, 4, 1'b0, 1, 1);   // R8 and R9 together, zero hold (R5)

        // Random sequences
        for (int k = 0; k < 24; k++) begin
            run_seq(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                    logic'($urandom % 2), bit'($urandom % 4 == 0), bit'($urandom % 4 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule